// File: doc/BRIEF.md
# SPI serial memory slave controller

This block is a synthesizable SPI slave that answers like a byte-wide serial EEPROM. A host selects it by pulling the chip-select low, clocks an 8-bit instruction in on the rising edges of the serial clock, and then, for memory accesses, sends a 16-bit byte address MSB first. Reads stream bytes out for as long as the host keeps clocking. The address steps up after each byte and wraps to zero past the top of the array. Writes collect up to one page of bytes in a buffer. They are committed by a self-timed internal cycle that starts when chip-select rises. During that cycle only the status read is honoured.

The serial pins are sampled by the system clock `clk` and must already be synchronous to it. The serial clock must stay at each level for at least three `clk` cycles. Chip-select must not rise until two `clk` cycles after the last rising edge of the serial clock. Both clock polarities are supported: serial clock idling low and serial clock idling high. A hold input pauses a transfer without losing its place. Writes are gated by the following:
- a write-enable latch;
- two block-protect bits that lock the upper quarter, the upper half or the whole array;
- a protect-enable bit that, together with a low write-protect pin, freezes the status register.

The array is held in on-chip registers with `2**MEM_AW` bytes. Setting MEM_AW to 15 gives the full 32K x 8 organisation.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `so_oe` is low. A status read right after reset returns 0x00. `so_oe` is low at the moment `cs_n` falls.
- R2: The instruction byte 0x06 sets the write-enable latch and 0x04 clears it. The latch is bit 1 of the status byte, which is read with instruction 0x05. In the status byte, bit 0 means busy, bits 3:2 are the block-protect code and bit 7 is the protect-enable.
- R3: Instruction 0x03 followed by a 16-bit address (MSB first) returns the addressed byte, MSB first, starting on the falling serial-clock edge after the last address bit. Further bytes come from the following addresses.
- R4: A read that passes address `2**MEM_AW-1` continues at address 0.
- R5: A page write (0x02) issued while the write-enable latch is clear changes no memory byte and starts no busy cycle.
- R6: A page write of whole bytes with the latch set starts the internal cycle on the rising edge of `cs_n`. Busy reads 1 for WR_CYCLES clock cycles. The written bytes then become readable and the latch reads 0.
- R7: During a page write, the column (the low PAGE_AW address bits) wraps inside the page. A byte sent past the page size overwrites the earlier byte at the same column.
- R8: While busy, every instruction except the status read is ignored, including 0x06 and 0x03. An ignored read leaves `so_oe` low.
- R9: Instruction 0x01 with a data byte loads the block-protect code (bits 3:2) and the protect-enable (bit 7), and runs a busy cycle. Code 01 protects the top quarter of the array, 10 the top half and 11 everything. A page write into a protected area is dropped without a busy cycle.
- R10: While the protect-enable is 1 and `wp_n` is low, instruction 0x01 is refused. When `wp_n` is high it is accepted.
- R11: `hold_n` taken low while `sck` is low pauses the transfer. `so_oe` goes low the next cycle, and `sck` and `si` are ignored. Raising `hold_n` while `sck` is low resumes the transfer at the same bit.
- R12: The same transfers work with `sck` idling high.
- R13: If `cs_n` rises in the middle of a byte during a page write, nothing is committed and the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in, sampled on the rising `sck` edge |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out, changes on the falling `sck` edge |
| so_oe | output | 1 | Output enable for `so` |

## Verification
An edge on `sck` registers one `clk` later. A received byte acts on the sequencer one `clk` after its eighth rising edge. An output bit is driven one `clk` after the falling edge that selects it. The bench therefore holds each `sck` level for four `clk` cycles and samples `so` just before the next rising edge, when every result is at least two cycles old. Busy rises one cycle after `cs_n` goes high and lasts WR_CYCLES cycles. Status reads are issued either well inside that window or after WR_CYCLES plus a margin has elapsed. The hold test checks `so_oe` four cycles after `hold_n` falls, well past its one-cycle latency.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

    typedef enum logic [7:0] {
        OP_WREN  = 8'h06,
        OP_WRDI  = 8'h04,
        OP_RDSR  = 8'h05,
        OP_WRSR  = 8'h01,
        OP_READ  = 8'h03,
        OP_WRITE = 8'h02
    } opcode_e;

    typedef enum logic [3:0] {
        SQ_OPC,
        SQ_AHI,
        SQ_ALO,
        SQ_RDOUT,
        SQ_WRIN,
        SQ_STOUT,
        SQ_STIN,
        SQ_STHELD,
        SQ_SKIP
    } seq_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } stat_t;

    function automatic logic [7:0] stat_byte(stat_t s);
        return {s.wpen, 3'b000, s.bp, s.wel, s.busy};
    endfunction

    // top2: two most significant array address bits
    function automatic logic blk_locked(logic [1:0] bp, logic [1:0] top2);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_eep_shifter.sv
module spi_eep_shifter
    import spi_eep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       hold_n,
    input  logic [7:0] tx_byte,
    input  logic       tx_en,
    output logic [7:0] rx_byte,
    output logic       rx_vld,
    output logic       tx_take,
    output logic       cs_rise,
    output logic       aligned,
    output logic       held,
    output logic       so,
    output logic       so_oe
);
    logic       sck_q, cs_q, paused, out_on;
    logic [2:0] bit_cnt;
    logic [6:0] in_sr;
    logic [7:0] out_sr;
    logic       live, s_rise, s_fall;

    assign live    = !cs_n && !paused;
    assign s_rise  = live && sck && !sck_q;
    assign s_fall  = live && !sck && sck_q;
    assign cs_rise = cs_n && !cs_q;
    assign aligned = (bit_cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            paused  <= 1'b0;
            out_on  <= 1'b0;
            bit_cnt <= '0;
            in_sr   <= '0;
            out_sr  <= '0;
            rx_byte <= '0;
            rx_vld  <= 1'b0;
            tx_take <= 1'b0;
        end else begin
            sck_q   <= sck;
            cs_q    <= cs_n;
            rx_vld  <= 1'b0;
            tx_take <= 1'b0;
            // pause state only changes while the serial clock is low
            if (cs_n)
                paused <= 1'b0;
            else if (!sck)
                paused <= !hold_n;
            if (cs_n) begin
                bit_cnt <= '0;
                out_on  <= 1'b0;
            end else begin
                if (s_rise) begin
                    in_sr   <= {in_sr[5:0], si};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        rx_byte <= {in_sr, si};
                        rx_vld  <= 1'b1;
                    end
                end
                if (s_fall) begin
                    if (aligned && tx_en) begin
                        out_sr  <= tx_byte;
                        out_on  <= 1'b1;
                        tx_take <= 1'b1;
                    end else begin
                        out_sr <= {out_sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign so    = out_sr[7];
    assign so_oe = live && out_on;
    assign held  = paused;

endmodule

// File: rtl/spi_eep_status.sv
module spi_eep_status
    import spi_eep_pkg::*;
#(
    parameter int WR_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wp_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       sr_load,
    input  logic       sr_wpen,
    input  logic [1:0] sr_bp,
    input  logic       launch,
    output stat_t      st,
    output logic       hw_lock,
    output logic       done
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] tmr;
    logic          wel_r, wpen_r;
    logic [1:0]    bp_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr    <= '0;
            wel_r  <= 1'b0;
            wpen_r <= 1'b0;
            bp_r   <= '0;
        end else begin
            if (launch)
                tmr <= CW'(WR_CYCLES);
            else if (tmr != '0)
                tmr <= tmr - 1'b1;

            if (launch)
                wel_r <= 1'b0;
            else if (set_wel)
                wel_r <= 1'b1;
            else if (clr_wel)
                wel_r <= 1'b0;

            if (sr_load) begin
                bp_r   <= sr_bp;
                wpen_r <= sr_wpen;
            end
        end
    end

    assign st.busy = (tmr != '0);
    assign st.wel  = wel_r;
    assign st.bp   = bp_r;
    assign st.wpen = wpen_r;
    assign hw_lock = wpen_r && !wp_n;
    assign done    = (tmr == CW'(1));

endmodule

// File: rtl/spi_eep_array.sv
module spi_eep_array #(
    parameter int MEM_AW  = 10,
    parameter int PAGE_AW = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [MEM_AW-1:0]          rd_addr,
    output logic [7:0]                 rd_data,
    input  logic                       pg_open,
    input  logic [MEM_AW-PAGE_AW-1:0]  pg_base_in,
    input  logic                       pg_we,
    input  logic [PAGE_AW-1:0]         pg_col,
    input  logic [7:0]                 pg_data,
    input  logic                       arm,
    input  logic                       done
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int PSZ   = 1 << PAGE_AW;
    localparam int RW    = MEM_AW - PAGE_AW;

    logic [7:0]     mem  [DEPTH];
    logic [7:0]     pbuf [PSZ];
    logic [PSZ-1:0] pmask;
    logic [RW-1:0]  pbase;
    logic           armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask <= '0;
            pbase <= '0;
            armed <= 1'b0;
        end else begin
            if (pg_open) begin
                pmask <= '0;
                pbase <= pg_base_in;
            end else if (pg_we) begin
                pmask[pg_col] <= 1'b1;
            end
            if (arm)
                armed <= 1'b1;
            else if (done)
                armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (pg_we)
            pbuf[pg_col] <= pg_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PSZ; i++) begin
            if (armed && done && pmask[i])
                mem[{pbase, PAGE_AW'(i)}] <= pbuf[i];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_eep_pkg::*;
#(
    parameter int MEM_AW    = 10,
    parameter int PAGE_AW   = 6,
    parameter int WR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    localparam int RW = MEM_AW - PAGE_AW;

    seq_e               state;
    logic [7:0]         a_hi;
    logic               rd_op;
    logic [MEM_AW-1:0]  addr;
    logic [PAGE_AW-1:0] col;
    logic               got_data;
    logic               sr_wpen_h;
    logic [1:0]         sr_bp_h;

    logic [7:0]  rx_byte, tx_byte, rd_data;
    logic        rx_vld, tx_take, cs_rise, aligned, held, tx_en;
    stat_t       st;
    logic        hw_lock, wr_done, busy, wel;
    logic        set_wel, clr_wel, sr_load, launch, pg_open, pg_we, page_ok, sr_ok;
    logic [15:0] full_addr;

    assign busy      = st.busy;
    assign wel       = st.wel;
    assign full_addr = {a_hi, rx_byte};
    assign tx_en     = (state == SQ_RDOUT) || (state == SQ_STOUT);
    assign tx_byte   = (state == SQ_RDOUT) ? rd_data : stat_byte(st);

    spi_eep_shifter u_shift (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .tx_byte(tx_byte), .tx_en(tx_en), .rx_byte(rx_byte), .rx_vld(rx_vld),
        .tx_take(tx_take), .cs_rise(cs_rise), .aligned(aligned), .held(held),
        .so(so), .so_oe(so_oe)
    );

    spi_eep_status #(.WR_CYCLES(WR_CYCLES)) u_stat (
        .clk(clk), .rst(rst), .wp_n(wp_n), .set_wel(set_wel), .clr_wel(clr_wel),
        .sr_load(sr_load), .sr_wpen(sr_wpen_h), .sr_bp(sr_bp_h), .launch(launch),
        .st(st), .hw_lock(hw_lock), .done(wr_done)
    );

    spi_eep_array #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_array (
        .clk(clk), .rst(rst), .rd_addr(addr), .rd_data(rd_data),
        .pg_open(pg_open), .pg_base_in(full_addr[MEM_AW-1:PAGE_AW]),
        .pg_we(pg_we), .pg_col(col), .pg_data(rx_byte),
        .arm(page_ok), .done(wr_done)
    );

    always_comb begin
        set_wel = 1'b0;
        clr_wel = 1'b0;
        pg_open = 1'b0;
        pg_we   = 1'b0;
        if (rx_vld && !cs_n) begin
            if (state == SQ_OPC && !busy) begin
                set_wel = (rx_byte == OP_WREN);
                clr_wel = (rx_byte == OP_WRDI);
            end
            if (state == SQ_ALO && !rd_op)
                pg_open = 1'b1;
            if (state == SQ_WRIN)
                pg_we = 1'b1;
        end
        page_ok = cs_rise && (state == SQ_WRIN) && aligned && got_data && wel &&
                  !busy && !blk_locked(st.bp, addr[MEM_AW-1 -: 2]);
        sr_ok   = cs_rise && (state == SQ_STHELD) && aligned && wel && !hw_lock && !busy;
        sr_load = sr_ok;
        launch  = page_ok || sr_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_OPC;
            a_hi      <= '0;
            rd_op     <= 1'b0;
            addr      <= '0;
            col       <= '0;
            got_data  <= 1'b0;
            sr_wpen_h <= 1'b0;
            sr_bp_h   <= '0;
        end else if (cs_n) begin
            state    <= SQ_OPC;
            got_data <= 1'b0;
        end else begin
            if (tx_take && state == SQ_RDOUT)
                addr <= addr + 1'b1;
            if (rx_vld) begin
                case (state)
                    SQ_OPC: begin
                        case (rx_byte)
                            OP_RDSR: state <= SQ_STOUT;
                            OP_READ: begin
                                rd_op <= 1'b1;
                                state <= busy ? SQ_SKIP : SQ_AHI;
                            end
                            OP_WRITE: begin
                                rd_op <= 1'b0;
                                state <= (!busy && wel) ? SQ_AHI : SQ_SKIP;
                            end
                            OP_WRSR:
                                state <= (!busy && wel && !hw_lock) ? SQ_STIN : SQ_SKIP;
                            default: state <= SQ_SKIP;
                        endcase
                    end
                    SQ_AHI: begin
                        a_hi  <= rx_byte;
                        state <= SQ_ALO;
                    end
                    SQ_ALO: begin
                        addr  <= full_addr[MEM_AW-1:0];
                        col   <= rx_byte[PAGE_AW-1:0];
                        state <= rd_op ? SQ_RDOUT : SQ_WRIN;
                    end
                    SQ_WRIN: begin
                        col      <= col + 1'b1;
                        got_data <= 1'b1;
                    end
                    SQ_STIN: begin
                        sr_wpen_h <= rx_byte[7];
                        sr_bp_h   <= rx_byte[3:2];
                        state     <= SQ_STHELD;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sck,
    input logic hold_n,
    input logic so_oe,
    input logic busy,
    input logic wel
);
    // R1
    sel_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !so_oe);

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold_n) && !sck && !cs_n) |=> !so_oe);

    // R6
    launch_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_n));

    // R5
    launch_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));

    // R8
    wel_frozen_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wel));

    // R6
    wel_clear_after_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .so_oe(so_oe), .busy(busy), .wel(wel)
);

// File: tb/spi_eeprom_slave_test.sv
`timescale 1ns/1ps
module spi_eeprom_slave_test;
    localparam int WRC = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;
    logic mode3 = 1'b0;
    int   nchk = 0, nerr = 0;
    logic [7:0] wb [0:79];
    logic [7:0] rb [0:7];

    always #2.5 clk = ~clk;

    spi_eeprom_slave #(.MEM_AW(10), .PAGE_AW(6), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sel();
        sck  = mode3;
        tick(2);
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel();
        if (!mode3) sck = 1'b0;
        tick(4);
        cs_n = 1'b1;
        tick(4);
    endtask

    // one byte, optional pause before sampling bit hb (8 = none)
    task automatic xbyte(input logic [7:0] din, input int hb,
                         output logic [7:0] dout, output logic oe_seen);
        oe_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = din[i];
            tick(4);
            if (i == hb) begin
                hold_n = 1'b0;
                tick(4);
                check(so_oe == 1'b0, "R11 pause releases so", so_oe, 0);
                sck = 1'b1; si = ~din[i];
                tick(4);
                sck = 1'b0;
                tick(4);
                hold_n = 1'b1; si = din[i];
                tick(4);
            end
            dout[i] = so;
            oe_seen = oe_seen | so_oe;
            sck = 1'b1;
            tick(4);
        end
    endtask

    task automatic sbyte(input logic [7:0] din);
        logic [7:0] d;
        logic o;
        xbyte(din, 8, d, o);
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel(); sbyte(op); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic o;
        sel(); sbyte(8'h05); xbyte(8'h00, 8, s, o); desel();
    endtask

    task automatic wsr(input logic [7:0] v);
        sel(); sbyte(8'h01); sbyte(v); desel();
    endtask

    task automatic wpage(input logic [15:0] a, input int n);
        sel(); sbyte(8'h02); sbyte(a[15:8]); sbyte(a[7:0]);
        for (int i = 0; i < n; i++) sbyte(wb[i]);
        desel();
    endtask

    task automatic rseq(input logic [15:0] a, input int n, input int hb, output logic oe_all);
        logic o;
        oe_all = 1'b1;
        sel(); sbyte(8'h03); sbyte(a[15:8]); sbyte(a[7:0]);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, (i == 0) ? hb : 8, rb[i], o);
            oe_all = oe_all & o;
        end
        desel();
    endtask

    task automatic wait_ready();
        tick(WRC + 20);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        check(so_oe == 1'b0, "R1 idle so_oe", so_oe, 0);
        rdsr(s);
        check(s == 8'h00, "R1 status after reset", s, 8'h00);
    endtask

    task automatic t_wel();
        logic [7:0] s;
        cmd1(8'h06); rdsr(s);
        check(s == 8'h02, "R2 latch set", s, 8'h02);
        cmd1(8'h04); rdsr(s);
        check(s == 8'h00, "R2 latch clear", s, 8'h00);
    endtask

    task automatic t_page();
        logic [7:0] s;
        logic oe;
        cmd1(8'h06);
        wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
        wpage(16'h0010, 4);
        rdsr(s);
        check(s == 8'h01, "R6 busy with latch cleared", s, 8'h01);
        wait_ready();
        rdsr(s);
        check(s == 8'h00, "R6 ready after cycle", s, 8'h00);
        rseq(16'h0010, 4, 8, oe);
        check(oe == 1'b1, "R3 output driven", oe, 1);
        check(rb[0] == 8'h11, "R3 byte 0", rb[0], 8'h11);
        check(rb[1] == 8'h22, "R3 byte 1", rb[1], 8'h22);
        check(rb[3] == 8'h44, "R3 byte 3", rb[3], 8'h44);
    endtask

    task automatic t_nowel();
        logic [7:0] s;
        logic oe;
        wb[0] = 8'hA5;
        wpage(16'h0010, 1);
        rdsr(s);
        check(s == 8'h00, "R5 no cycle without latch", s, 8'h00);
        rseq(16'h0010, 1, 8, oe);
        check(rb[0] == 8'h11, "R5 memory unchanged", rb[0], 8'h11);
    endtask

    task automatic t_busy();
        logic [7:0] s;
        logic oe;
        cmd1(8'h06);
        wb[0] = 8'h5A;
        wpage(16'h0000, 1);
        rseq(16'h0010, 2, 8, oe);
        check(oe == 1'b0, "R8 read ignored while busy", oe, 0);
        cmd1(8'h06);
        wait_ready();
        rdsr(s);
        check(s == 8'h00, "R8 latch set ignored while busy", s, 8'h00);
        rseq(16'h0000, 1, 8, oe);
        check(rb[0] == 8'h5A, "R6 byte at zero", rb[0], 8'h5A);
    endtask

    task automatic t_pgwrap();
        logic oe;
        cmd1(8'h06);
        for (int i = 0; i < 5; i++) wb[i] = 8'hB0 + 8'(i);
        wpage(16'h03FE, 5);
        wait_ready();
        rseq(16'h03FE, 3, 8, oe);
        check(rb[0] == 8'hB0, "R7 column 62", rb[0], 8'hB0);
        check(rb[1] == 8'hB1, "R4 top byte", rb[1], 8'hB1);
        check(rb[2] == 8'h5A, "R4 read wraps to zero", rb[2], 8'h5A);
        rseq(16'h03C0, 3, 8, oe);
        check(rb[0] == 8'hB2, "R7 column wrap 0", rb[0], 8'hB2);
        check(rb[2] == 8'hB4, "R7 column wrap 2", rb[2], 8'hB4);
    endtask

    task automatic t_overflow();
        logic oe;
        cmd1(8'h06);
        for (int i = 0; i < 65; i++) wb[i] = 8'h40 + 8'(i);
        wpage(16'h0080, 65);
        wait_ready();
        rseq(16'h0080, 2, 8, oe);
        check(rb[0] == 8'h80, "R7 overwrite first column", rb[0], 8'h80);
        check(rb[1] == 8'h41, "R7 second column kept", rb[1], 8'h41);
    endtask

    task automatic t_partial();
        logic [7:0] s, d;
        logic o;
        cmd1(8'h06);
        sel(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h10); sbyte(8'hEE);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; si = 1'b1; tick(4); sck = 1'b1; tick(4);
        end
        desel();
        rdsr(s);
        check(s == 8'h02, "R13 no cycle, latch kept", s, 8'h02);
        rseq(16'h0010, 1, 8, o);
        d = rb[0];
        check(d == 8'h11, "R13 memory unchanged", d, 8'h11);
        cmd1(8'h04);
    endtask

    task automatic t_hold();
        logic oe;
        rseq(16'h0010, 2, 3, oe);
        check(rb[0] == 8'h11, "R11 byte across pause", rb[0], 8'h11);
        check(rb[1] == 8'h22, "R11 next byte after pause", rb[1], 8'h22);
    endtask

    task automatic t_mode3();
        logic [7:0] s;
        logic oe;
        cs_n = 1'b1; mode3 = 1'b1; sck = 1'b1; tick(4);
        rdsr(s);
        check(s == 8'h00, "R12 status read, clock idle high", s, 8'h00);
        rseq(16'h0011, 2, 8, oe);
        check(rb[0] == 8'h22, "R12 read byte 0", rb[0], 8'h22);
        check(rb[1] == 8'h33, "R12 read byte 1", rb[1], 8'h33);
        mode3 = 1'b0; sck = 1'b0; tick(4);
    endtask

    task automatic t_protect();
        logic [7:0] s;
        logic oe;
        cmd1(8'h06); wsr(8'h0C);
        rdsr(s);
        check(s == 8'h0D, "R9 status write busy", s, 8'h0D);
        wait_ready();
        rdsr(s);
        check(s == 8'h0C, "R9 full protect code", s, 8'h0C);
        cmd1(8'h06); wb[0] = 8'h99; wpage(16'h0010, 1);
        rdsr(s);
        check(s == 8'h0E, "R9 protected write dropped", s, 8'h0E);
        rseq(16'h0010, 1, 8, oe);
        check(rb[0] == 8'h11, "R9 protected byte kept", rb[0], 8'h11);
        wsr(8'h04); wait_ready();
        cmd1(8'h06); wb[0] = 8'h77; wpage(16'h03C0, 1);
        rdsr(s);
        check(s == 8'h06, "R9 top quarter dropped", s, 8'h06);
        wb[0] = 8'h66; wpage(16'h0020, 1);
        wait_ready();
        rseq(16'h03C0, 1, 8, oe);
        check(rb[0] == 8'hB2, "R9 top quarter kept", rb[0], 8'hB2);
        rseq(16'h0020, 1, 8, oe);
        check(rb[0] == 8'h66, "R9 low area written", rb[0], 8'h66);
    endtask

    task automatic t_wpen();
        logic [7:0] s;
        cmd1(8'h06); wsr(8'h80); wait_ready();
        wp_n = 1'b0;
        cmd1(8'h06); wsr(8'h0C);
        rdsr(s);
        check(s == 8'h82, "R10 status write refused", s, 8'h82);
        wp_n = 1'b1;
        wsr(8'h00); wait_ready();
        rdsr(s);
        check(s == 8'h00, "R10 status write with pin high", s, 8'h00);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_wel();
        t_page();
        t_nowel();
        t_busy();
        t_pgwrap();
        t_overflow();
        t_partial();
        t_hold();
        t_mode3();
        t_protect();
        t_wpen();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule